// File: doc/BRIEF.md
# Link Request Serial Decoder

This block turns a single serial request line into a parallel request. A link-layer controller drives the line one bit per system clock, and the line rests at 0 between requests. A request opens with a 1. The next three bits name the kind of request, and that kind fixes how many more bits follow: a speed code, a register address, an address plus a write byte, or a single control bit. Every request closes with a 0.

When a request arrives intact, the decoder raises a one-cycle valid strobe. In that same cycle it presents the kind and the fields that belong to it. If the kind is not legal, or the closing bit is wrong, the decoder pulses an error flag instead and goes back to waiting for a start bit. The decoder does not act on the request itself; whatever is downstream consumes the strobe and the fields.

Top module: `link_req_deser`

## Requirements
- R1: While idle, a 0 on `req_line` keeps the decoder idle and changes no output. A sampled 1 is taken as the start bit of a request.
- R2: The three bits after the start bit carry the kind, most significant bit first. Code 0 is a bus request, 1 is a register read, 2 is a register write and 3 is acceleration control. On valid, `req_kind` shows the same code.
- R3: A bus request is 7 bits long. Bits 4 and 5 form the speed code, MSB first. The code is passed to `req_speed` unchanged, including the reserved value.
- R4: A register read is 9 bits long. Bits 4 to 7 form the register address, MSB first, and appear on `req_addr`.
- R5: A register write is 17 bits long. Bits 4 to 7 form the address and bits 8 to 15 form the write data, both MSB first. They appear on `req_addr` and `req_wdata`.
- R6: An acceleration-control request is 6 bits long. Its bit 4 appears on `req_wdata` bit 0.
- R7: On valid, any output field that the request kind does not carry reads as zero.
- R8: `req_valid` is high for exactly one cycle, the cycle after the closing 0 is sampled. A start bit sampled in the very next cycle begins a new request.
- R9: If the closing bit of a request is 1, `frame_err` pulses for one cycle and no valid is given. The decoder returns to idle, and `req_kind`, `req_speed`, `req_addr` and `req_wdata` keep their previous values.
- R10: A kind code from 4 to 7 makes `frame_err` pulse in the cycle after bit 3 is sampled, with no valid. The decoder then treats the following bit as a possible start bit.
- R11: While `rst` is high at a clock edge, the decoder goes to idle and every output is cleared to zero, even in the middle of a request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the serial line is sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_line | input | 1 | Serial request line, idle low |
| req_valid | output | 1 | One-cycle strobe marking a decoded request |
| req_kind | output | 2 | Request kind: 0 bus, 1 read, 2 write, 3 acceleration |
| req_speed | output | SPD_W (2) | Speed code of a bus request |
| req_addr | output | ADDR_W (4) | Register address of a read or write |
| req_wdata | output | DATA_W (8) | Write data, or the acceleration bit in bit 0 |
| frame_err | output | 1 | One-cycle pulse on a bad closing bit or an illegal kind |

## Verification
Each legal kind is sent with several field values, including all-zero and all-one, so that any slip in field boundaries or bit order shows up in the captured values. Requests are also sent back to back with no idle gap, which shows whether the decoder can take a start bit in the cycle right after a closing bit. Bad closing bits, illegal kind codes followed at once by a new start bit, and a reset in the middle of a request each exercise a different return path to idle. A long random mix of kinds, payloads, gaps and occasional errors is then compared cycle by cycle against a behavioural model.

// File: rtl/lrd_pkg.sv
package lrd_pkg;

  typedef enum logic [1:0] {
    KIND_BUS = 2'd0,
    KIND_RD  = 2'd1,
    KIND_WR  = 2'd2,
    KIND_ACC = 2'd3
  } req_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TYPE = 2'd1,
    ST_PAY  = 2'd2,
    ST_STOP = 2'd3
  } seq_state_e;

endpackage

// File: rtl/lrd_seq.sv
module lrd_seq
  import lrd_pkg::*;
#(
  parameter int TYPE_W = 3,
  parameter int SPD_W  = 2,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int ACC_W  = 1
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      line_i,
  output logic      pay_clr,
  output logic      pay_en,
  output logic      stop_ok,
  output logic      stop_bad,
  output logic      type_bad,
  output req_kind_e kind_o
);

  localparam int PAY_W = ADDR_W + DATA_W;
  localparam int CNT_W = $clog2(PAY_W + 1);

  seq_state_e          state_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [TYPE_W-2:0]   tsh_q;
  req_kind_e           kind_q;
  logic [TYPE_W-1:0]   type_full;
  logic                type_legal;
  logic                cnt_zero;
  req_kind_e           kind_next;

  function automatic logic [CNT_W-1:0] pay_len(input req_kind_e k);
    case (k)
      KIND_BUS: return CNT_W'(SPD_W);
      KIND_RD:  return CNT_W'(ADDR_W);
      KIND_WR:  return CNT_W'(ADDR_W + DATA_W);
      default:  return CNT_W'(ACC_W);
    endcase
  endfunction

  assign type_full  = {tsh_q, line_i};
  assign type_legal = (type_full[TYPE_W-1:2] == '0);
  assign kind_next  = req_kind_e'(type_full[1:0]);
  assign cnt_zero   = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      tsh_q   <= '0;
      kind_q  <= KIND_BUS;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (line_i) begin
            state_q <= ST_TYPE;
            cnt_q   <= CNT_W'(TYPE_W - 1);
            tsh_q   <= '0;
          end
        end
        ST_TYPE: begin
          tsh_q <= type_full[TYPE_W-2:0];
          if (cnt_zero) begin
            if (type_legal) begin
              kind_q  <= kind_next;
              cnt_q   <= pay_len(kind_next) - CNT_W'(1);
              state_q <= ST_PAY;
            end else begin
              state_q <= ST_IDLE;
            end
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        ST_PAY: begin
          if (cnt_zero) state_q <= ST_STOP;
          else          cnt_q   <= cnt_q - CNT_W'(1);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign pay_clr  = (state_q == ST_IDLE) && line_i;
  assign pay_en   = (state_q == ST_PAY);
  assign stop_ok  = (state_q == ST_STOP) && !line_i;
  assign stop_bad = (state_q == ST_STOP) && line_i;
  assign type_bad = (state_q == ST_TYPE) && cnt_zero && !type_legal;
  assign kind_o   = kind_q;

  // R1
  idle_start_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && line_i) |=> (state_q == ST_TYPE));

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && !line_i) |=> (state_q == ST_IDLE));

  // R8
  stop_to_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_STOP) |=> (state_q == ST_IDLE));

  // R10
  type_bad_idle_chk: assert property (@(posedge clk) disable iff (rst)
    type_bad |=> (state_q == ST_IDLE));

endmodule

// File: rtl/lrd_payload.sv
module lrd_payload #(
  parameter int PAY_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic             bit_i,
  output logic [PAY_W-1:0] pay_o
);

  logic [PAY_W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst || clr) sh_q <= '0;
    else if (en)    sh_q <= {sh_q[PAY_W-2:0], bit_i};
  end

  assign pay_o = sh_q;

  // R5
  shift_in_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !clr) |=> (sh_q[0] == $past(bit_i)));

endmodule

// File: rtl/lrd_outreg.sv
module lrd_outreg
  import lrd_pkg::*;
#(
  parameter int SPD_W  = 2,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int ACC_W  = 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     stop_ok,
  input  logic                     stop_bad,
  input  logic                     type_bad,
  input  req_kind_e                kind_i,
  input  logic [ADDR_W+DATA_W-1:0] pay_i,
  output logic                     req_valid,
  output logic [1:0]               req_kind,
  output logic [SPD_W-1:0]         req_speed,
  output logic [ADDR_W-1:0]        req_addr,
  output logic [DATA_W-1:0]        req_wdata,
  output logic                     frame_err
);

  localparam int PAY_W = ADDR_W + DATA_W;

  logic [SPD_W-1:0]  spd_n;
  logic [ADDR_W-1:0] addr_n;
  logic [DATA_W-1:0] data_n;

  always_comb begin
    spd_n  = '0;
    addr_n = '0;
    data_n = '0;
    case (kind_i)
      KIND_BUS: spd_n  = pay_i[SPD_W-1:0];
      KIND_RD:  addr_n = pay_i[ADDR_W-1:0];
      KIND_WR: begin
        addr_n = pay_i[PAY_W-1:DATA_W];
        data_n = pay_i[DATA_W-1:0];
      end
      default:  data_n = DATA_W'(pay_i[ACC_W-1:0]);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_valid <= 1'b0;
      frame_err <= 1'b0;
      req_kind  <= '0;
      req_speed <= '0;
      req_addr  <= '0;
      req_wdata <= '0;
    end else begin
      req_valid <= stop_ok;
      frame_err <= stop_bad || type_bad;
      if (stop_ok) begin
        req_kind  <= kind_i;
        req_speed <= spd_n;
        req_addr  <= addr_n;
        req_wdata <= data_n;
      end
    end
  end

  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> !req_valid);

  // R9
  valid_err_excl_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> !frame_err);

  // R7
  bus_fields_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind == 2'd0) |-> (req_addr == '0 && req_wdata == '0));

  // R9
  err_hold_chk: assert property (@(posedge clk) disable iff (rst)
    frame_err |-> ($stable(req_addr) && $stable(req_wdata) && $stable(req_speed)));

endmodule

// File: rtl/link_req_deser.sv
module link_req_deser
  import lrd_pkg::*;
#(
  parameter int TYPE_W = 3,
  parameter int SPD_W  = 2,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int ACC_W  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_line,
  output logic              req_valid,
  output logic [1:0]        req_kind,
  output logic [SPD_W-1:0]  req_speed,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_wdata,
  output logic              frame_err
);

  localparam int PAY_W = ADDR_W + DATA_W;

  logic             pay_clr;
  logic             pay_en;
  logic             stop_ok;
  logic             stop_bad;
  logic             type_bad;
  req_kind_e        kind_w;
  logic [PAY_W-1:0] pay_w;

  lrd_seq #(
    .TYPE_W(TYPE_W), .SPD_W(SPD_W), .ADDR_W(ADDR_W),
    .DATA_W(DATA_W), .ACC_W(ACC_W)
  ) seq_i (
    .clk(clk), .rst(rst), .line_i(req_line),
    .pay_clr(pay_clr), .pay_en(pay_en),
    .stop_ok(stop_ok), .stop_bad(stop_bad), .type_bad(type_bad),
    .kind_o(kind_w)
  );

  lrd_payload #(.PAY_W(PAY_W)) pay_i (
    .clk(clk), .rst(rst), .clr(pay_clr), .en(pay_en),
    .bit_i(req_line), .pay_o(pay_w)
  );

  lrd_outreg #(
    .SPD_W(SPD_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ACC_W(ACC_W)
  ) out_i (
    .clk(clk), .rst(rst),
    .stop_ok(stop_ok), .stop_bad(stop_bad), .type_bad(type_bad),
    .kind_i(kind_w), .pay_i(pay_w),
    .req_valid(req_valid), .req_kind(req_kind), .req_speed(req_speed),
    .req_addr(req_addr), .req_wdata(req_wdata), .frame_err(frame_err)
  );

endmodule

// File: tb/link_req_deser_tb_top.sv
module link_req_deser_tb_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       line = 1'b0;
  logic       req_valid, frame_err;
  logic [1:0] req_kind, req_speed;
  logic [3:0] req_addr;
  logic [7:0] req_wdata;

  int    n_chk = 0;
  int    n_fail = 0;
  int    cyc = 0;
  bit    done = 1'b0;
  string tag = "R11";

  // behavioural model state
  bit         m_busy = 1'b0;
  int         m_bits[$];
  int         m_len = 0;
  int         m_t = 0;
  logic       m_valid = 1'b0, m_err = 1'b0;
  logic [1:0] m_kind = '0, m_spd = '0;
  logic [3:0] m_addr = '0;
  logic [7:0] m_wdata = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_req_deser dut_i (
    .clk(clk), .rst(rst), .req_line(line),
    .req_valid(req_valid), .req_kind(req_kind), .req_speed(req_speed),
    .req_addr(req_addr), .req_wdata(req_wdata), .frame_err(frame_err)
  );

  always @(posedge clk) begin
    int n;
    int val;
    m_valid = 1'b0;
    m_err   = 1'b0;
    if (rst) begin
      m_busy = 1'b0;
      m_bits.delete();
      m_kind = '0; m_spd = '0; m_addr = '0; m_wdata = '0;
    end else if (!m_busy) begin
      if (line) begin
        m_busy = 1'b1;
        m_bits.delete();
      end
    end else begin
      m_bits.push_back(int'(line));
      n = m_bits.size();
      if (n == 3) begin
        m_t = m_bits[0] * 4 + m_bits[1] * 2 + m_bits[2];
        if (m_t > 3) begin
          m_err  = 1'b1;
          m_busy = 1'b0;
        end else begin
          m_len = (m_t == 0) ? 6 : (m_t == 1) ? 8 : (m_t == 2) ? 16 : 5;
        end
      end else if (n > 3 && n == m_len) begin
        m_busy = 1'b0;
        if (line) m_err = 1'b1;
        else begin
          m_valid = 1'b1;
          val = 0;
          for (int i = 3; i < n - 1; i++) val = val * 2 + m_bits[i];
          m_kind = 2'(m_t);
          m_spd = '0; m_addr = '0; m_wdata = '0;
          case (m_t)
            0: m_spd = 2'(val);
            1: m_addr = 4'(val);
            2: begin m_addr = 4'(val >> 8); m_wdata = 8'(val & 255); end
            default: m_wdata = 8'(val);
          endcase
        end
      end
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(negedge clk) begin
    if (!done) begin
      n_chk++;
      if (req_valid !== m_valid || frame_err !== m_err || req_kind !== m_kind ||
          req_speed !== m_spd || req_addr !== m_addr || req_wdata !== m_wdata) begin
        n_fail++;
        $display("FAIL %s t=%0t: got v=%b e=%b k=%0d s=%0d a=%h d=%h exp v=%b e=%b k=%0d s=%0d a=%h d=%h",
                 tag, $time, req_valid, frame_err, req_kind, req_speed, req_addr, req_wdata,
                 m_valid, m_err, m_kind, m_spd, m_addr, m_wdata);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_fail++;
      $display("FAIL watchdog: got cycle %0d expected completion before 150000", cyc);
      finish_run();
    end
  end

  task automatic drive_bit(input logic b);
    @(negedge clk);
    line = b;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive_bit(1'b0);
  endtask

  task automatic send_field(input int v, input int w);
    for (int i = w - 1; i >= 0; i--) drive_bit(1'(v >> i));
  endtask

  function automatic int plen(input int t);
    return (t == 0) ? 2 : (t == 1) ? 4 : (t == 2) ? 12 : 1;
  endfunction

  task automatic send_req(input int t, input int pay, input logic stopb);
    drive_bit(1'b1);
    send_field(t, 3);
    send_field(pay, plen(t));
    drive_bit(stopb);
  endtask

  initial begin
    // R11: reset state
    tag = "R11";
    idle(3);
    @(negedge clk);
    n_chk++;
    if (req_valid !== 1'b0 || frame_err !== 1'b0 || req_kind !== 2'd0 ||
        req_speed !== 2'd0 || req_addr !== 4'd0 || req_wdata !== 8'd0) begin
      n_fail++;
      $display("FAIL R11: got outputs v=%b e=%b a=%h d=%h expected all zero",
               req_valid, frame_err, req_addr, req_wdata);
    end
    rst = 1'b0;

    tag = "R1"; idle(10);
    tag = "R3";
    for (int s = 0; s < 4; s++) begin send_req(0, s, 1'b0); idle(2); end
    tag = "R4";
    send_req(1, 0, 1'b0); idle(1);
    send_req(1, 5, 1'b0); idle(1);
    send_req(1, 15, 1'b0); idle(1);
    tag = "R5";
    send_req(2, 12'hA5C, 1'b0); idle(2);
    send_req(2, 12'hFFF, 1'b0); idle(2);
    send_req(2, 12'h001, 1'b0); idle(2);
    tag = "R6";
    send_req(3, 1, 1'b0); idle(2);
    send_req(3, 0, 1'b0); idle(2);
    tag = "R7";
    send_req(2, 12'h7E3, 1'b0);
    send_req(0, 2, 1'b0); idle(2);
    tag = "R2";
    send_req(1, 9, 1'b0); send_req(3, 1, 1'b0); idle(1);
    tag = "R8";
    send_req(1, 3, 1'b0); send_req(2, 12'h4C8, 1'b0);
    send_req(0, 1, 1'b0); send_req(3, 1, 1'b0); idle(3);
    tag = "R9";
    send_req(0, 3, 1'b1); idle(2);
    send_req(2, 12'h123, 1'b1); idle(2);
    send_req(1, 6, 1'b1); send_req(1, 10, 1'b0); idle(2);
    tag = "R10";
    drive_bit(1'b1); send_field(5, 3);
    send_req(0, 3, 1'b0); idle(2);
    drive_bit(1'b1); send_field(7, 3); idle(3);
    drive_bit(1'b1); send_field(4, 3);
    send_req(2, 12'hBEE, 1'b0); idle(2);
    tag = "R11";
    drive_bit(1'b1); send_field(2, 3); send_field(3, 4);
    @(negedge clk); rst = 1'b1; line = 1'b0;
    @(negedge clk); rst = 1'b0;
    idle(3);
    send_req(1, 11, 1'b0); idle(2);
    tag = "R8";
    for (int k = 0; k < 400; k++) begin
      int t;
      int r;
      t = $urandom_range(0, 3);
      r = $urandom_range(0, 15);
      if (r == 0) begin
        drive_bit(1'b1); send_field($urandom_range(4, 7), 3);
      end else begin
        send_req(t, $urandom_range(0, 4095) & ((1 << plen(t)) - 1), (r == 1) ? 1'b1 : 1'b0);
      end
      idle($urandom_range(0, 3));
    end
    idle(4);
    finish_run();
  end

endmodule